// File: doc/BRIEF.md
# Pseudo-SRAM Byte-Lane Interface

This block is a clock-synchronous model of the control side of a 16-bit pseudo-SRAM. On every rising clock edge it samples a primary chip select, a power-down select, write and output enables, and one enable for each byte lane. From these it performs a word or single-byte read or write on a small internal array. Read data appears on a registered output bus. A separate two-bit lane-drive vector tells the enclosing pad logic which half of the bus to drive, so the tri-state buffer itself stays outside the block.

The block has three power modes: standby, active and deep power-down. It moves into deep power-down only from a deselected standby cycle. Deep power-down destroys the array contents, so on entry every byte lane of every word is flagged as holding unknown data. A read that touches such a lane raises a stale indication until that lane is written again.

Top module: `psram_lane_ctrl`

## Requirements
- R1: When `rst_n` is low, the block enters standby (`pwr_mode` = 0). It clears `dq_oe`, `dq_out` and `rd_stale`, zeroes the array and marks every lane of every word as unknown.
- R2: A cycle with `ce1_n` high performs no read or write, whatever the other control pins are. The next `pwr_mode` is 0 (standby), unless R3 applies, and `dq_oe` is 0.
- R3: In standby, a cycle with `ce1_n` high and `ce2` low moves the block to deep power-down (`pwr_mode` = 2) at that edge. While there, `dq_oe` stays 0 and every pin except `ce2` is ignored. A cycle with `ce2` high returns the block to standby and performs no access in that cycle.
- R4: Deep power-down is never entered straight from active (`pwr_mode` = 1). With `ce1_n` low, a low `ce2` is ignored and the access proceeds.
- R5: Entering deep power-down marks every lane of every word as unknown. After return, a read of such a lane sets `rd_stale`.
- R6: A read is a cycle with `ce1_n` low, `we_n` high and `oe_n` low. After that edge, `dq_oe[1]` equals the inverse of `ub_n` and `dq_oe[0]` equals the inverse of `lb_n`. A selected lane drives its byte (bits 15:8 upper, 7:0 lower). An unselected lane is not driven and reads as zero.
- R7: A selected cycle with `we_n` and `oe_n` both high drives neither lane.
- R8: A write (`ce1_n` low, `we_n` low) stores `dq_in[15:8]` when `ub_n` is low and `dq_in[7:0]` when `lb_n` is low. An unselected byte keeps its previous value.
- R9: A write with both `ub_n` and `lb_n` high changes no stored data.
- R10: A write takes place even when `oe_n` is low. Neither lane is driven after a write cycle.
- R11: `rd_stale` is 1 after a read in which any selected lane holds unknown data, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Primary chip select, active low |
| ce2 | input | 1 | Power-down select, low requests deep power-down |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 2 | Lane drive: bit 1 upper byte, bit 0 lower byte |
| rd_stale | output | 1 | Last read touched a lane with unknown data |
| pwr_mode | output | 2 | 0 standby, 1 active, 2 deep power-down |

## Verification
A wrong power-mode state shows up on `pwr_mode` right after the edge that produced it. It also shows one cycle later as an access that was wrongly accepted or refused, seen in `dq_oe` and in the data read back. A corrupted lane-valid bit stays hidden until that word is read, and then appears on `rd_stale` one cycle after the read. A wrong write mask likewise stays hidden until a later read returns the wrong byte. For that reason every write in the stimulus is followed by reads of both lanes, and reads also follow ignored writes and a deep power-down round trip.

// File: rtl/psram_lane_pkg.sv
package psram_lane_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'd0,
        PM_ACTIVE  = 2'd1,
        PM_DEEP    = 2'd2
    } pmode_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [LANES-1:0] lanes;
    } access_s;
endpackage

// File: rtl/psram_mode_fsm.sv
module psram_mode_fsm
    import psram_lane_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ce1_n,
    input  logic   ce2,
    output pmode_e mode_q,
    output logic   access_ok,
    output logic   wipe
);
    typedef struct packed {
        pmode_e mode;
    } fsm_s;

    fsm_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        access_ok = 1'b0;
        wipe      = 1'b0;
        unique case (st_q.mode)
            PM_DEEP: begin
                // every pin except ce2 is ignored here
                if (ce2) st_d.mode = PM_STANDBY;
            end
            PM_STANDBY: begin
                if (!ce1_n) begin
                    access_ok  = 1'b1;
                    st_d.mode  = PM_ACTIVE;
                end else if (!ce2) begin
                    wipe       = 1'b1;
                    st_d.mode  = PM_DEEP;
                end
            end
            default: begin
                if (!ce1_n) begin
                    access_ok  = 1'b1;
                end else begin
                    st_d.mode  = PM_STANDBY;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: PM_STANDBY};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;

    // R4: active never steps straight into deep power-down
    p_no_deep_from_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_ACTIVE) |=> (mode_q != PM_DEEP));

    // R3: deep power-down is held while ce2 stays low
    p_deep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_DEEP && !ce2) |=> (mode_q == PM_DEEP));
endmodule

// File: rtl/psram_lane_array.sv
module psram_lane_array
    import psram_lane_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic              wipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        typedef struct packed {
            logic [DEPTH-1:0][LANE_W-1:0] data;
            logic [DEPTH-1:0]             vld;
        } lane_s;

        lane_s ln_d, ln_q;

        always_comb begin
            ln_d = ln_q;
            if (wipe) begin
                ln_d.vld = '0;
            end else if (wr_en && wr_lanes[g]) begin
                ln_d.data[addr] = wdata[g*LANE_W +: LANE_W];
                ln_d.vld[addr]  = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign rdata[g*LANE_W +: LANE_W] = ln_q.data[addr];
        assign rvalid[g]                 = ln_q.vld[addr];

        // R5: entering deep power-down leaves no lane marked known
        p_wipe_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            wipe |=> (ln_q.vld == '0));
    end
endmodule

// File: rtl/psram_read_port.sv
module psram_read_port
    import psram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  access_s           acc,
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  rvalid,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              rd_stale
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  oe;
        logic              stale;
    } out_s;

    out_s o_d, o_q;

    always_comb begin
        o_d = '0;
        if (acc.rd) begin
            o_d.oe    = acc.lanes;
            o_d.stale = |(acc.lanes & ~rvalid);
            for (int i = 0; i < LANES; i++) begin
                if (acc.lanes[i]) o_d.data[i*LANE_W +: LANE_W] = rdata[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dq_out   = o_q.data;
    assign dq_oe    = o_q.oe;
    assign rd_stale = o_q.stale;

    // R10: a write cycle is never followed by a driven lane
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr |=> (dq_oe == '0));
endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl
    import psram_lane_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              rd_stale,
    output logic [1:0]        pwr_mode
);
    pmode_e            mode_q;
    logic              access_ok;
    logic              wipe;
    access_s           acc;
    logic [DATA_W-1:0] rdata;
    logic [LANES-1:0]  rvalid;

    psram_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .mode_q    (mode_q),
        .access_ok (access_ok),
        .wipe      (wipe)
    );

    always_comb begin
        acc.lanes = ~{ub_n, lb_n};
        acc.wr    = access_ok && !we_n;
        acc.rd    = access_ok && we_n && !oe_n;
    end

    psram_lane_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc.wr),
        .wr_lanes (acc.lanes),
        .wipe     (wipe),
        .addr     (addr),
        .wdata    (dq_in),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    psram_read_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .rd_stale (rd_stale)
    );

    assign pwr_mode = mode_q;

    // R3: nothing is driven while in deep power-down
    p_deep_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_DEEP) |-> (dq_oe == 2'b00));

    // R2: a deselected cycle leaves both lanes undriven
    p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce1_n |=> (dq_oe == 2'b00));

    // R6: a driven upper lane was requested by ub_n in the sampled cycle
    p_upper_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |=> !dq_oe[1]);
endmodule

// File: tb/psram_lane_ctrl_test.sv
module psram_lane_ctrl_test;
    typedef struct packed {
        logic        ce1_n;
        logic        ce2;
        logic        we_n;
        logic        oe_n;
        logic        ub_n;
        logic        lb_n;
        logic [3:0]  addr;
        logic [15:0] din;
        logic [1:0]  e_oe;
        logic [15:0] e_dq;
        logic        dq_chk;
        logic        e_stale;
        logic [1:0]  e_mode;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd1,16'hA1B2,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 0 R8 word write
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'hA1B2,1'b1,1'b0,2'd1}, // 1 R6 word read
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'd1,16'h5500,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 2 R8 upper write
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h55B2,1'b1,1'b0,2'd1}, // 3 R8 lower kept
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'd1,16'h00CC,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 4 R10 write, oe low
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h55CC,1'b1,1'b0,2'd1}, // 5 R10 stored
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'd1,16'h0000,2'b10,16'h5500,1'b1,1'b0,2'd1}, // 6 R6 upper read
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'd1,16'h0000,2'b01,16'h00CC,1'b1,1'b0,2'd1}, // 7 R6 lower read
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'd1,16'hFFFF,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 8 R9 no-lane write
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h55CC,1'b1,1'b0,2'd1}, // 9 R9 unchanged
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,4'd1,16'h0000,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 10 R7 output disable
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd2,16'h0000,2'b11,16'h0000,1'b1,1'b1,2'd1}, // 11 R11 unwritten
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3,16'h1234,2'b00,16'h0000,1'b1,1'b0,2'd0}, // 12 R2 deselected write
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd3,16'h0000,2'b11,16'h0000,1'b1,1'b1,2'd1}, // 13 R2 ignored
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h55CC,1'b1,1'b0,2'd1}, // 14 R4 ce2 low, active
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'd0,16'h0000,2'b00,16'h0000,1'b1,1'b0,2'd0}, // 15 R4 to standby only
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'd0,16'h0000,2'b00,16'h0000,1'b1,1'b0,2'd2}, // 16 R3 enter deep
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd4,16'h7777,2'b00,16'h0000,1'b1,1'b0,2'd2}, // 17 R3 pins ignored
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'd0,16'h0000,2'b00,16'h0000,1'b1,1'b0,2'd0}, // 18 R5 exit to standby
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h0000,1'b0,1'b1,2'd1}, // 19 R5 stale after deep
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd4,16'h0000,2'b11,16'h0000,1'b1,1'b1,2'd1}, // 20 R3 write was dropped
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'd1,16'h0011,2'b00,16'h0000,1'b1,1'b0,2'd1}, // 21 R8 rewrite lower
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'd1,16'h0000,2'b01,16'h0011,1'b1,1'b0,2'd1}, // 22 R11 lower known
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1,16'h0000,2'b11,16'h0000,1'b0,1'b1,2'd1}  // 23 R5 upper still stale
    };

    function automatic string tag_of(int i);
        case (i)
            1, 6, 7:        return "R6";
            0, 2, 3, 21:    return "R8";
            4, 5:           return "R10";
            8, 9:           return "R9";
            10:             return "R7";
            11, 22:         return "R11";
            12, 13:         return "R2";
            14, 15:         return "R4";
            16, 17, 20:     return "R3";
            default:        return "R5";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        rd_stale;
    logic [1:0]  pwr_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psram_lane_ctrl #(.ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .rd_stale(rd_stale), .pwr_mode(pwr_mode)
    );

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        @(negedge clk);
        ce1_n = v.ce1_n; ce2 = v.ce2; we_n = v.we_n; oe_n = v.oe_n;
        ub_n = v.ub_n; lb_n = v.lb_n; addr = v.addr; dq_in = v.din;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        ce1_n = 1'b1; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", "reset mode", {14'd0, pwr_mode}, 16'd0);
        check("R1", "reset lane drive", {14'd0, dq_oe}, 16'd0);
        check("R1", "reset data", dq_out, 16'd0);
        check("R1", "reset stale", {15'd0, rd_stale}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check(tag_of(i), $sformatf("row %0d mode", i), {14'd0, pwr_mode}, {14'd0, TBL[i].e_mode});
            check(tag_of(i), $sformatf("row %0d lane drive", i), {14'd0, dq_oe}, {14'd0, TBL[i].e_oe});
            check(tag_of(i), $sformatf("row %0d stale", i), {15'd0, rd_stale}, {15'd0, TBL[i].e_stale});
            if (TBL[i].dq_chk)
                check(tag_of(i), $sformatf("row %0d data", i), dq_out, TBL[i].e_dq);
        end

        // R1: reset in mid-run returns to standby and forgets stored lanes
        apply('{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd5,16'hBEEF,2'b00,16'h0,1'b0,1'b0,2'd1});
        @(negedge clk);
        rst_n = 1'b0;
        ce1_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1", "mid reset mode", {14'd0, pwr_mode}, 16'd0);
        check("R1", "mid reset lane drive", {14'd0, dq_oe}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        apply('{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'd5,16'h0,2'b11,16'h0,1'b1,1'b1,2'd1});
        check("R1", "after reset stale", {15'd0, rd_stale}, 16'd1);
        check("R1", "after reset data", dq_out, 16'h0000);

        // R11: read with no lane selected touches nothing and is not stale
        apply('{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd5,16'h0,2'b00,16'h0,1'b1,1'b0,2'd1});
        check("R11", "no-lane read stale", {15'd0, rd_stale}, 16'd0);
        check("R6", "no-lane read drive", {14'd0, dq_oe}, 16'd0);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule